// File: doc/BRIEF.md
# Programmable Message Time Tag

This block keeps a free-running 16-bit real-time count used to time-stamp messages on a serial command/response bus. A single-cycle 1 µs tick pulse feeds a prescaler whose division ratio comes from a 3-bit resolution select. Each time the prescaler completes a period, the count steps by one.

When the bus message engine signals that a message has begun or has ended, the block raises a one-cycle write request. The request carries the count at the moment of the event and a slot code that tells the message stack which of its two time-tag words to fill. A synchronize-with-data command overwrites the count with a supplied value. An optional filter mode keeps the present least significant bit during that overwrite.

Top module: `msg_time_tag`

## Requirements
- R1: While reset is asserted and after its release, `count_o` reads 0 and `cap_valid_o` is low until a tick period or an event occurs.
- R2: The count rises by exactly one each time the prescaler completes a period and wraps from 0xFFFF to 0x0000.
- R3: Select code n in 0..5 makes one count step take 2^(n+1) tick pulses (2, 4, 8, 16, 32, 64 µs). Codes 6 and 7 both give 64 tick pulses.
- R4: A pulse on `som_i` or `eom_i`, with nothing held, raises `cap_valid_o` for exactly one cycle on the next cycle. `cap_value_o` then equals the `count_o` of the event cycle, and `cap_slot_o` is 0 for start-of-message and 1 for end-of-message.
- R5: With `sync_i` high and `lsb_keep_i` low, the next `count_o` equals `sync_data_i`. This load wins over a count step due in the same cycle.
- R6: With `sync_i` and `lsb_keep_i` both high, the next `count_o` takes bits 15:1 from `sync_data_i` and keeps its own bit 0.
- R7: Start and end events in the same cycle give two back-to-back requests: start first, then end, both carrying the count of the event cycle. A held request is always issued before any newly arriving one.
- R8: Any change of the select code clears the prescaler. A tick in the cycle of the change is not counted, so the next step needs a full new period of ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_1us_i | input | 1 | One-cycle pulse every microsecond |
| res_sel_i | input | 3 | Resolution select code |
| som_i | input | 1 | Start-of-message event pulse |
| eom_i | input | 1 | End-of-message event pulse |
| sync_i | input | 1 | Synchronize-with-data load command |
| sync_data_i | input | 16 | Value for the synchronize load |
| lsb_keep_i | input | 1 | Keep bit 0 of the count on synchronize loads |
| count_o | output | 16 | Current time-tag count |
| cap_valid_o | output | 1 | Stack write request, one cycle |
| cap_slot_o | output | 1 | Slot of the request: 0 start, 1 end |
| cap_value_o | output | 16 | Count captured for the request |

## Verification
A tick that completes a period, and a synchronize load, both show on `count_o` right after the edge that samples them, so the bench drives each input on a falling edge and reads the count on the next falling edge. A capture request appears one edge after its event and a deferred end request one edge later. The bench therefore inspects `cap_valid_o` on each of the next three falling edges, expecting the pattern on, on, off for a collision and on, off for a lone event. Resolution is measured by counting the tick pulses needed to move the count after a select change that has been absorbed in an idle cycle.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int unsigned TT_CNT_W   = 16;
  localparam int unsigned TT_SEL_W   = 3;
  localparam int unsigned TT_NUM_RES = 6;

  typedef enum logic [0:0] {
    SLOT_SOM = 1'b0,
    SLOT_EOM = 1'b1
  } slot_e;
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int unsigned SEL_W   = tt_pkg::TT_SEL_W,
  parameter int unsigned NUM_RES = tt_pkg::TT_NUM_RES
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             adv_o
);
  localparam int unsigned PRE_W = NUM_RES;
  localparam int unsigned IDX_W = (NUM_RES > 1) ? $clog2(NUM_RES) : 1;

  logic [PRE_W-1:0] lim_tab [NUM_RES];

  // Terminal value per resolution: 2^(g+1) ticks per step.
  for (genvar g = 0; g < NUM_RES; g++) begin : g_lim
    assign lim_tab[g] = PRE_W'((1 << (g + 1)) - 1);
  end

  logic [PRE_W-1:0] pcnt_q, pcnt_d;
  logic [SEL_W-1:0] sel_q;
  logic [IDX_W-1:0] eff_idx;
  logic             sel_chg;
  logic             hit;

  always_comb begin
    if (sel_i >= SEL_W'(NUM_RES)) eff_idx = IDX_W'(NUM_RES - 1);
    else                          eff_idx = IDX_W'(sel_i);
  end

  assign sel_chg = (sel_i != sel_q);
  assign hit     = tick_i && (pcnt_q == lim_tab[eff_idx]);

  always_comb begin
    pcnt_d = pcnt_q;
    if (sel_chg)     pcnt_d = '0;
    else if (hit)    pcnt_d = '0;
    else if (tick_i) pcnt_d = pcnt_q + PRE_W'(1);
  end

  assign adv_o = hit && !sel_chg;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      sel_q  <= '0;
    end else begin
      if (sel_chg || tick_i) pcnt_q <= pcnt_d;
      if (sel_chg)           sel_q  <= sel_i;
    end
  end
endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int unsigned CNT_W = tt_pkg::TT_CNT_W
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             sync_i,
  input  logic [CNT_W-1:0] sync_data_i,
  input  logic             lsb_keep_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = sync_i || adv_i;

  always_comb begin
    cnt_d = cnt_q;
    if (sync_i) begin
      if (lsb_keep_i) cnt_d = {sync_data_i[CNT_W-1:1], cnt_q[0]};
      else            cnt_d = sync_data_i;
    end else if (adv_i) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/tt_capture.sv
module tt_capture #(
  parameter int unsigned CNT_W = tt_pkg::TT_CNT_W
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             som_i,
  input  logic             eom_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             cap_valid_o,
  output tt_pkg::slot_e    cap_slot_o,
  output logic [CNT_W-1:0] cap_value_o,
  output logic             pend_o
);
  import tt_pkg::*;

  logic             out_v_q, out_v_d;
  slot_e            out_s_q, out_s_d;
  logic [CNT_W-1:0] out_c_q, out_c_d;
  logic             hold_v_q, hold_v_d;
  slot_e            hold_s_q, hold_s_d;
  logic [CNT_W-1:0] hold_c_q, hold_c_d;
  logic             load_out, load_hold;

  always_comb begin
    out_v_d  = 1'b0;
    out_s_d  = out_s_q;
    out_c_d  = out_c_q;
    hold_v_d = 1'b0;
    hold_s_d = hold_s_q;
    hold_c_d = hold_c_q;
    if (hold_v_q) begin
      out_v_d = 1'b1;
      out_s_d = hold_s_q;
      out_c_d = hold_c_q;
      if (som_i) begin
        hold_v_d = 1'b1;
        hold_s_d = SLOT_SOM;
        hold_c_d = count_i;
      end else if (eom_i) begin
        hold_v_d = 1'b1;
        hold_s_d = SLOT_EOM;
        hold_c_d = count_i;
      end
    end else if (som_i) begin
      out_v_d = 1'b1;
      out_s_d = SLOT_SOM;
      out_c_d = count_i;
      if (eom_i) begin
        hold_v_d = 1'b1;
        hold_s_d = SLOT_EOM;
        hold_c_d = count_i;
      end
    end else if (eom_i) begin
      out_v_d = 1'b1;
      out_s_d = SLOT_EOM;
      out_c_d = count_i;
    end
  end

  assign load_out  = out_v_d;
  assign load_hold = hold_v_d;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      out_v_q  <= 1'b0;
      out_s_q  <= SLOT_SOM;
      out_c_q  <= '0;
      hold_v_q <= 1'b0;
      hold_s_q <= SLOT_SOM;
      hold_c_q <= '0;
    end else begin
      out_v_q  <= out_v_d;
      hold_v_q <= hold_v_d;
      if (load_out) begin
        out_s_q <= out_s_d;
        out_c_q <= out_c_d;
      end
      if (load_hold) begin
        hold_s_q <= hold_s_d;
        hold_c_q <= hold_c_d;
      end
    end
  end

  assign cap_valid_o = out_v_q;
  assign cap_slot_o  = out_s_q;
  assign cap_value_o = out_c_q;
  assign pend_o      = hold_v_q;
endmodule

// File: rtl/msg_time_tag.sv
module msg_time_tag #(
  parameter int unsigned CNT_W   = tt_pkg::TT_CNT_W,
  parameter int unsigned SEL_W   = tt_pkg::TT_SEL_W,
  parameter int unsigned NUM_RES = tt_pkg::TT_NUM_RES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_1us_i,
  input  logic [SEL_W-1:0] res_sel_i,
  input  logic             som_i,
  input  logic             eom_i,
  input  logic             sync_i,
  input  logic [CNT_W-1:0] sync_data_i,
  input  logic             lsb_keep_i,
  output logic [CNT_W-1:0] count_o,
  output logic             cap_valid_o,
  output logic             cap_slot_o,
  output logic [CNT_W-1:0] cap_value_o
);
  logic [1:0]     rst_pipe_q;
  logic           rst_sync_n;
  logic           adv_w;
  logic           pend_w;
  tt_pkg::slot_e  slot_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  tt_prescaler #(.SEL_W(SEL_W), .NUM_RES(NUM_RES)) pre_i (
    .clk    (clk),
    .rst_ni (rst_sync_n),
    .tick_i (tick_1us_i),
    .sel_i  (res_sel_i),
    .adv_o  (adv_w)
  );

  tt_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk         (clk),
    .rst_ni      (rst_sync_n),
    .adv_i       (adv_w),
    .sync_i      (sync_i),
    .sync_data_i (sync_data_i),
    .lsb_keep_i  (lsb_keep_i),
    .count_o     (count_o)
  );

  tt_capture #(.CNT_W(CNT_W)) cap_i (
    .clk         (clk),
    .rst_ni      (rst_sync_n),
    .som_i       (som_i),
    .eom_i       (eom_i),
    .count_i     (count_o),
    .cap_valid_o (cap_valid_o),
    .cap_slot_o  (slot_w),
    .cap_value_o (cap_value_o),
    .pend_o      (pend_w)
  );

  assign cap_slot_o = slot_w;
endmodule

// File: rtl/tt_checker.sv
module tt_checker #(
  parameter int unsigned CNT_W = tt_pkg::TT_CNT_W
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             som_i,
  input logic             eom_i,
  input logic             sync_i,
  input logic [CNT_W-1:0] sync_data_i,
  input logic             lsb_keep_i,
  input logic [CNT_W-1:0] count_o,
  input logic             cap_valid_o,
  input logic             cap_slot_o,
  input logic [CNT_W-1:0] cap_value_o,
  input logic             pend_i
);
  // R2: without a load the count holds or steps by one
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    !sync_i |=> (count_o == $past(count_o)) || (count_o == CNT_W'($past(count_o) + CNT_W'(1))));

  // R5: full synchronize load
  assert_sync_load_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (sync_i && !lsb_keep_i) |=> (count_o == $past(sync_data_i)));

  // R6: filtered load keeps bit 0
  assert_lsb_keep_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (sync_i && lsb_keep_i) |=> (count_o[CNT_W-1:1] == $past(sync_data_i[CNT_W-1:1]))
                            && (count_o[0] == $past(count_o[0])));

  // R4: lone start event gives a start request with the event-cycle count
  assert_som_capture_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (som_i && !eom_i && !pend_i) |=> cap_valid_o && (cap_slot_o == 1'b0)
                                     && (cap_value_o == $past(count_o)));

  // R4: a request always has a cause one cycle earlier
  assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    cap_valid_o |-> $past(som_i || eom_i || pend_i));

  // R7: collision order is start then end
  assert_collide_order_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (som_i && eom_i && !pend_i) |=> (cap_valid_o && cap_slot_o == 1'b0)
                                    ##1 (cap_valid_o && cap_slot_o == 1'b1));
endmodule

bind msg_time_tag tt_checker #(.CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst_ni      (rst_sync_n),
  .som_i       (som_i),
  .eom_i       (eom_i),
  .sync_i      (sync_i),
  .sync_data_i (sync_data_i),
  .lsb_keep_i  (lsb_keep_i),
  .count_o     (count_o),
  .cap_valid_o (cap_valid_o),
  .cap_slot_o  (cap_slot_o),
  .cap_value_o (cap_value_o),
  .pend_i      (pend_w)
);

// File: tb/msg_time_tag_tb_top.sv
`timescale 1ns/1ps
module msg_time_tag_tb_top;
  logic        clk;
  logic        rst_n;
  logic        tick;
  logic [2:0]  sel;
  logic        som, eom, sync, keep;
  logic [15:0] sdata;
  logic [15:0] count;
  logic        cvalid, cslot;
  logic [15:0] cvalue;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  msg_time_tag dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1us_i(tick), .res_sel_i(sel),
    .som_i(som), .eom_i(eom), .sync_i(sync), .sync_data_i(sdata),
    .lsb_keep_i(keep), .count_o(count), .cap_valid_o(cvalid),
    .cap_slot_o(cslot), .cap_value_o(cvalue)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Resolution table: {select code, ticks per step}
  localparam int NV = 8;
  localparam int VEC [NV][2] = '{
    '{0, 2}, '{1, 4}, '{2, 8}, '{3, 16},
    '{4, 32}, '{5, 64}, '{6, 64}, '{7, 64}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Ticks every cycle until the count moves; returns how many were needed.
  task automatic ticks_to_step(output int n);
    logic [15:0] c0;
    c0 = count;
    n = 0;
    tick = 1'b1;
    for (int k = 0; k < 100; k++) begin
      step();
      n++;
      if (count != c0) break;
    end
    tick = 1'b0;
  endtask

  task automatic load(input logic [15:0] v, input logic k);
    sync = 1'b1; sdata = v; keep = k;
    step();
    sync = 1'b0; keep = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    logic [15:0] c0;
    rst_n = 1'b0; tick = 1'b0; sel = 3'd0; som = 1'b0; eom = 1'b0;
    sync = 1'b0; sdata = '0; keep = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 count in reset", 32'(count), 32'h0);
    check("R1 no request in reset", 32'(cvalid), 32'h0);
    rst_n = 1'b1;
    repeat (4) step();
    check("R1 count after release", 32'(count), 32'h0);
    check("R1 no request after release", 32'(cvalid), 32'h0);

    // R3: table walk of all select codes
    for (int i = 0; i < NV; i++) begin
      sel = 3'(VEC[i][0]);
      step();
      c0 = count;
      ticks_to_step(n);
      check($sformatf("R3 ticks per step, code %0d", VEC[i][0]), 32'(n), 32'(VEC[i][1]));
      check("R2 step of one", 32'(count), 32'(16'(c0 + 16'd1)));
    end

    // R8: change of select with a tick in the same cycle
    sel = 3'd2; step();
    tick = 1'b1; repeat (5) step();
    c0 = count;
    sel = 3'd1; step();
    tick = 1'b0;
    check("R8 no step in change cycle", 32'(count), 32'(c0));
    ticks_to_step(n);
    check("R8 full period after change", 32'(n), 32'd4);

    // R5: load wins over a due step
    sel = 3'd1; step(); sel = 3'd0; step();
    tick = 1'b1; step();
    sync = 1'b1; sdata = 16'h5555; step();
    sync = 1'b0; tick = 1'b0;
    check("R5 load beats step", 32'(count), 32'h5555);
    load(16'h1234, 1'b0);
    check("R5 plain load", 32'(count), 32'h1234);

    // R2: wrap
    load(16'hFFFF, 1'b0);
    tick = 1'b1; step();
    check("R2 half period no step", 32'(count), 32'hFFFF);
    step(); tick = 1'b0;
    check("R2 wrap to zero", 32'(count), 32'h0000);

    // R6: filtered loads
    load(16'h1234, 1'b0);
    load(16'hABCD, 1'b1);
    check("R6 keep bit0 clear", 32'(count), 32'hABCC);
    load(16'h0003, 1'b0);
    load(16'h0010, 1'b1);
    check("R6 keep bit0 set", 32'(count), 32'h0011);

    // R4: lone start, lone end
    load(16'h0A0A, 1'b0);
    som = 1'b1; step(); som = 1'b0;
    check("R4 start valid", 32'(cvalid), 32'h1);
    check("R4 start slot", 32'(cslot), 32'h0);
    check("R4 start value", 32'(cvalue), 32'h0A0A);
    step();
    check("R4 start single cycle", 32'(cvalid), 32'h0);
    load(16'h0B0B, 1'b0);
    eom = 1'b1; step(); eom = 1'b0;
    check("R4 end valid", 32'(cvalid), 32'h1);
    check("R4 end slot", 32'(cslot), 32'h1);
    check("R4 end value", 32'(cvalue), 32'h0B0B);
    step();
    check("R4 end single cycle", 32'(cvalid), 32'h0);

    // R7: collision
    load(16'h0C0C, 1'b0);
    som = 1'b1; eom = 1'b1; step(); som = 1'b0; eom = 1'b0;
    check("R7 first valid", 32'(cvalid), 32'h1);
    check("R7 first slot start", 32'(cslot), 32'h0);
    check("R7 first value", 32'(cvalue), 32'h0C0C);
    step();
    check("R7 second valid", 32'(cvalid), 32'h1);
    check("R7 second slot end", 32'(cslot), 32'h1);
    check("R7 second value", 32'(cvalue), 32'h0C0C);
    step();
    check("R7 then idle", 32'(cvalid), 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule